// File: doc/BRIEF.md
# Dual-Role General Register File with Program Counter

This block holds the integer architectural state of a 64-bit processor core: thirty-one ordinary general registers, a stack pointer, a program counter and a next-PC register. Index 31 has two meanings. Each port carries its own mode bit that chooses between them. With the bit set, index 31 reaches the real stack-pointer register. With the bit clear, index 31 is a zero source, and writes to it are dropped.

There are two combinational read ports and one synchronous write port. Every port carries an operand width (8, 16, 32 or 64 bits). The read ports also carry a signedness bit. Narrow reads are extended to 64 bits, by sign or by zero. Narrow writes clear every bit above the operand.

The sequencing section moves next-PC into PC on an update strobe and then advances next-PC by one instruction. It accepts an absolute next-PC load or a PC-relative branch, and it can copy next-PC into the link register (index 30) in the cycle before a branch is installed.

Top module: `gpr_bank`

## Requirements
- R1: A read of index 31 with that port's stack-pointer mode bit clear returns zero, whatever the width and signedness.
- R2: A write to index 31 with the write port's stack-pointer mode bit clear changes no register.
- R3: With the mode bit set, index 31 is a real register that is written and read back like the others.
- R4: The width code is 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64. A 64-bit write stores all bits. A narrower write stores the low bits of the data and clears all bits above them.
- R5: A read of width 8, 16 or 32 returns the low bits of the register, sign-extended when the signed bit is 1 and zero-extended when it is 0. A 64-bit read returns the whole register.
- R6: With write enable low and no link save, no register changes.
- R7: A read of a register in the same cycle it is written returns the value held before that write.
- R8: On the update strobe, PC takes the effective next-PC, and next-PC becomes that value plus 4.
- R9: Next-PC is loaded either with an absolute value or with PC plus a signed 64-bit offset, and the absolute load wins when both are asked. Without the update strobe, only next-PC changes. With the strobe in the same cycle, PC takes the loaded target.
- R10: A link save copies the next-PC value held before the clock edge into register 30. It takes priority over a write-port write to register 30 in the same cycle.
- R11: Reset clears every register, sets PC to the reset-vector parameter and sets next-PC to the reset vector plus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_idx | input | 5 | Read port A register index |
| ra_sp | input | 1 | Port A: index 31 is the stack pointer when 1, zero when 0 |
| ra_width | input | 2 | Port A operand width code |
| ra_signed | input | 1 | Port A sign-extends a narrow result when 1 |
| ra_data | output | 64 | Port A read data |
| rb_idx | input | 5 | Read port B register index |
| rb_sp | input | 1 | Port B stack-pointer mode bit |
| rb_width | input | 2 | Port B operand width code |
| rb_signed | input | 1 | Port B signedness |
| rb_data | output | 64 | Port B read data |
| we | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_sp | input | 1 | Write port stack-pointer mode bit |
| wr_width | input | 2 | Write operand width code |
| wr_data | input | 64 | Write data |
| link_save | input | 1 | Copy next-PC into register 30 |
| npc_load | input | 1 | Load next-PC with npc_value |
| npc_branch | input | 1 | Load next-PC with PC plus npc_value |
| npc_value | input | 64 | Absolute target or signed offset |
| pc_step | input | 1 | Update strobe: install next-PC as PC |
| pc_out | output | 64 | Program counter |
| npc_out | output | 64 | Next program counter |

## Verification
Two cases are the hardest to reach from the ports. The first is a link save and a write-port write to register 30 in the same cycle. The second is a branch or load in the same cycle as the update strobe, where PC must take the new target and not the stale next-PC. The stimulus drives both collisions on purpose and checks the result through a 64-bit read and the PC outputs. A full sweep fills every index with a distinct pattern that has its sign bit set at some widths and clear at others. It then reads each one back through both ports at every width and signedness, so the extension boundaries at bits 7, 15 and 31 are exercised on both sides.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef enum logic [1:0] {
    OPW_8  = 2'd0,
    OPW_16 = 2'd1,
    OPW_32 = 2'd2,
    OPW_64 = 2'd3
  } opw_e;
endpackage

// File: rtl/gpr_rstsync.sv
module gpr_rstsync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/gpr_rdport.sv
module gpr_rdport
  import gpr_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic [NREG-1:0][XLEN-1:0] regs_i,
  input  logic [IDXW-1:0]           idx_i,
  input  logic                      sp_i,
  input  logic [1:0]                width_i,
  input  logic                      sgn_i,
  output logic [XLEN-1:0]           data_o
);
  localparam logic [IDXW-1:0] ZR_IDX = IDXW'(NREG - 1);

  logic [XLEN-1:0] raw;

  always_comb begin
    raw = ((idx_i == ZR_IDX) && !sp_i) ? '0 : regs_i[idx_i];
    unique case (opw_e'(width_i))
      OPW_8:   data_o = {{(XLEN-8){sgn_i & raw[7]}},   raw[7:0]};
      OPW_16:  data_o = {{(XLEN-16){sgn_i & raw[15]}}, raw[15:0]};
      OPW_32:  data_o = {{(XLEN-32){sgn_i & raw[31]}}, raw[31:0]};
      default: data_o = raw;
    endcase
  end
endmodule

// File: rtl/gpr_pcseq.sv
module gpr_pcseq #(
  parameter int              XLEN      = 64,
  parameter logic [XLEN-1:0] RESET_VEC = '0,
  parameter int              STEP      = 4
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic            load_i,
  input  logic            branch_i,
  input  logic [XLEN-1:0] val_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] npc_o
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  logic [XLEN-1:0] pc_q, pc_d, npc_q, npc_d, tgt;
  logic            en;

  always_comb begin
    if (load_i)        tgt = val_i;
    else if (branch_i) tgt = pc_q + val_i;
    else               tgt = npc_q;
    pc_d  = step_i ? tgt : pc_q;
    npc_d = step_i ? (tgt + STEP_V) : tgt;
    en    = step_i | load_i | branch_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= RESET_VEC;
      npc_q <= RESET_VEC + STEP_V;
    end else if (en) begin
      pc_q  <= pc_d;
      npc_q <= npc_d;
    end
  end

  assign pc_o  = pc_q;
  assign npc_o = npc_q;
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
  import gpr_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter int              NREG      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 64'h0000_0000_0000_1000,
  parameter int              STEP      = 4,
  localparam int             IDXW      = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] ra_idx,
  input  logic            ra_sp,
  input  logic [1:0]      ra_width,
  input  logic            ra_signed,
  output logic [XLEN-1:0] ra_data,
  input  logic [IDXW-1:0] rb_idx,
  input  logic            rb_sp,
  input  logic [1:0]      rb_width,
  input  logic            rb_signed,
  output logic [XLEN-1:0] rb_data,
  input  logic            we,
  input  logic [IDXW-1:0] wr_idx,
  input  logic            wr_sp,
  input  logic [1:0]      wr_width,
  input  logic [XLEN-1:0] wr_data,
  input  logic            link_save,
  input  logic            npc_load,
  input  logic            npc_branch,
  input  logic [XLEN-1:0] npc_value,
  input  logic            pc_step,
  output logic [XLEN-1:0] pc_out,
  output logic [XLEN-1:0] npc_out
);
  localparam logic [IDXW-1:0] ZR_IDX   = IDXW'(NREG - 1);
  localparam int              LINK_IDX = NREG - 2;

  logic                      rst_sync_n;
  logic [NREG-1:0][XLEN-1:0] regs_q, regs_d;
  logic [XLEN-1:0]           wval;
  logic                      wr_hit, file_en;

  gpr_rstsync u_rst (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  always_comb begin
    unique case (opw_e'(wr_width))
      OPW_8:   wval = {{(XLEN-8){1'b0}},  wr_data[7:0]};
      OPW_16:  wval = {{(XLEN-16){1'b0}}, wr_data[15:0]};
      OPW_32:  wval = {{(XLEN-32){1'b0}}, wr_data[31:0]};
      default: wval = wr_data;
    endcase
    wr_hit  = we && !((wr_idx == ZR_IDX) && !wr_sp);
    file_en = wr_hit | link_save;
    regs_d  = regs_q;
    if (wr_hit)    regs_d[wr_idx]   = wval;
    if (link_save) regs_d[LINK_IDX] = npc_out;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  regs_q <= '0;
    else if (file_en) regs_q <= regs_d;
  end

  logic [1:0][IDXW-1:0] rp_idx;
  logic [1:0]           rp_sp, rp_sgn;
  logic [1:0][1:0]      rp_w;
  logic [1:0][XLEN-1:0] rp_data;

  assign rp_idx = {rb_idx, ra_idx};
  assign rp_sp  = {rb_sp, ra_sp};
  assign rp_sgn = {rb_signed, ra_signed};
  assign rp_w   = {rb_width, ra_width};

  for (genvar p = 0; p < 2; p++) begin : g_rd
    gpr_rdport #(.XLEN(XLEN), .NREG(NREG)) u_rd (
      .regs_i  (regs_q),
      .idx_i   (rp_idx[p]),
      .sp_i    (rp_sp[p]),
      .width_i (rp_w[p]),
      .sgn_i   (rp_sgn[p]),
      .data_o  (rp_data[p])
    );
  end

  assign ra_data = rp_data[0];
  assign rb_data = rp_data[1];

  gpr_pcseq #(.XLEN(XLEN), .RESET_VEC(RESET_VEC), .STEP(STEP)) u_pc (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .step_i   (pc_step),
    .load_i   (npc_load),
    .branch_i (npc_branch),
    .val_i    (npc_value),
    .pc_o     (pc_out),
    .npc_o    (npc_out)
  );
endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk #(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  parameter int STEP = 4,
  localparam int IDXW = $clog2(NREG)
) (
  input logic                      clk,
  input logic                      rst_ni,
  input logic [IDXW-1:0]           ra_idx,
  input logic                      ra_sp,
  input logic [XLEN-1:0]           ra_data,
  input logic [IDXW-1:0]           rb_idx,
  input logic                      rb_sp,
  input logic [XLEN-1:0]           rb_data,
  input logic                      we,
  input logic [IDXW-1:0]           wr_idx,
  input logic                      wr_sp,
  input logic                      link_save,
  input logic                      npc_load,
  input logic [XLEN-1:0]           npc_value,
  input logic                      pc_step,
  input logic [XLEN-1:0]           pc_out,
  input logic [XLEN-1:0]           npc_out,
  input logic [NREG-1:0][XLEN-1:0] regs_q
);
  localparam logic [IDXW-1:0] ZR = IDXW'(NREG - 1);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  p_zero_rda_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (ra_idx == ZR && !ra_sp) |-> ra_data == '0);
  p_zero_rdb_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (rb_idx == ZR && !rb_sp) |-> rb_data == '0);
  p_zr_drop_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (we && wr_idx == ZR && !wr_sp && !link_save) |=> regs_q == $past(regs_q));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!we && !link_save) |=> $stable(regs_q));
  p_step_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    pc_step |=> npc_out == pc_out + STEP_V);
  p_pc_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    !pc_step |=> $stable(pc_out));
  p_abs_load_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (npc_load && !pc_step) |=> npc_out == $past(npc_value));
  p_link_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    link_save |=> regs_q[NREG-2] == $past(npc_out));
endmodule

bind gpr_bank gpr_bank_chk #(.XLEN(XLEN), .NREG(NREG), .STEP(STEP)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_sync_n),
  .ra_idx    (ra_idx),
  .ra_sp     (ra_sp),
  .ra_data   (ra_data),
  .rb_idx    (rb_idx),
  .rb_sp     (rb_sp),
  .rb_data   (rb_data),
  .we        (we),
  .wr_idx    (wr_idx),
  .wr_sp     (wr_sp),
  .link_save (link_save),
  .npc_load  (npc_load),
  .npc_value (npc_value),
  .pc_step   (pc_step),
  .pc_out    (pc_out),
  .npc_out   (npc_out),
  .regs_q    (regs_q)
);

// File: tb/test_gpr_bank.sv
module test_gpr_bank;
  localparam logic [63:0] RV = 64'h0000_0000_0000_1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  ra_idx, rb_idx, wr_idx;
  logic        ra_sp, rb_sp, wr_sp, ra_signed, rb_signed;
  logic [1:0]  ra_width, rb_width, wr_width;
  logic [63:0] ra_data, rb_data, wr_data, npc_value, pc_out, npc_out;
  logic        we, link_save, npc_load, npc_branch, pc_step;

  int errs = 0, checks = 0;
  bit done = 0;
  logic [63:0] mdl [32];

  always #4 clk = ~clk;

  gpr_bank #(.RESET_VEC(RV)) i_gpr_bank (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_rd(int idx, bit sp, int w, bit sgn);
    logic [63:0] raw, mask;
    int bits;
    raw  = (idx == 31 && !sp) ? 64'd0 : mdl[idx];
    bits = 8 << w;
    if (bits == 64) return raw;
    mask = (64'd1 << bits) - 64'd1;
    if (sgn && raw[bits-1]) return (raw & mask) | ~mask;
    return raw & mask;
  endfunction

  function automatic logic [63:0] exp_wr(logic [63:0] d, int w);
    if (w == 3) return d;
    return d & ((64'd1 << (8 << w)) - 64'd1);
  endfunction

  task automatic do_write(int idx, bit sp, int w, logic [63:0] d);
    we = 1; wr_idx = 5'(idx); wr_sp = sp; wr_width = 2'(w); wr_data = d;
    @(posedge clk); #1;
    we = 0;
    if (!(idx == 31 && !sp)) mdl[idx] = exp_wr(d, w);
  endtask

  task automatic rd_both(int idx, bit sp, int w, bit sgn, string tag);
    ra_idx = 5'(idx); ra_sp = sp; ra_width = 2'(w); ra_signed = sgn;
    rb_idx = 5'(idx); rb_sp = sp; rb_width = 2'(w); rb_signed = sgn;
    #1;
    chk({tag, " portA"}, ra_data, exp_rd(idx, sp, w, sgn));
    chk({tag, " portB"}, rb_data, exp_rd(idx, sp, w, sgn));
  endtask

  task automatic tick();
    @(posedge clk); #1;
    pc_step = 0; npc_load = 0; npc_branch = 0; link_save = 0;
  endtask

  initial begin
    rst_n = 0; we = 0; wr_idx = 0; wr_sp = 0; wr_width = 3; wr_data = 0;
    ra_idx = 0; rb_idx = 0; ra_sp = 1; rb_sp = 1; ra_width = 3; rb_width = 3;
    ra_signed = 0; rb_signed = 0; link_save = 0; npc_load = 0;
    npc_branch = 0; npc_value = 0; pc_step = 0;
    for (int i = 0; i < 32; i++) mdl[i] = 64'd0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset pc", pc_out, RV);
    chk("R11 reset npc", npc_out, RV + 64'd4);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < 32; i++) rd_both(i, 1, 3, 0, "R11 reset reg clear");

    // fill every index, 31 as stack pointer (R3, R4 64-bit)
    for (int i = 0; i < 32; i++)
      do_write(i, 1, 3, 64'h0123_4567_89AB_CDEF * 64'(i + 1) ^ {32'(i), 32'h0080_8000});
    for (int i = 0; i < 32; i++) rd_both(i, 1, 3, 0, "R3/R4 full readback");

    // zero source on index 31 (R1)
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 2; s++) rd_both(31, 0, w, s[0], "R1 zero read");

    // width / sign sweep (R5)
    for (int i = 0; i < 32; i++)
      for (int w = 0; w < 4; w++)
        for (int s = 0; s < 2; s++) rd_both(i, 1, w, s[0], "R5 extend");

    // narrow writes clear upper bits (R4)
    for (int w = 0; w < 4; w++) begin
      do_write(5, 1, 3, 64'hFFFF_FFFF_FFFF_FFFF);
      do_write(5, 1, w, 64'hDEAD_BEEF_8765_43F1);
      rd_both(5, 1, 3, 0, "R4 narrow write");
    end

    // dropped write to zero index (R2)
    do_write(31, 0, 3, 64'h5555_AAAA_5555_AAAA);
    rd_both(31, 1, 3, 0, "R2 zr write dropped");
    for (int i = 0; i < 31; i++) rd_both(i, 1, 3, 0, "R2 others untouched");

    // write enable low (R6)
    we = 0; wr_idx = 7; wr_sp = 1; wr_width = 3; wr_data = 64'h1111_2222_3333_4444;
    @(posedge clk); #1;
    rd_both(7, 1, 3, 0, "R6 we low");

    // same-cycle read returns old value (R7)
    we = 1; wr_idx = 9; wr_sp = 1; wr_width = 3; wr_data = 64'hCAFE_F00D_0000_0009;
    ra_idx = 9; ra_sp = 1; ra_width = 3; ra_signed = 0; #1;
    chk("R7 old value same cycle", ra_data, mdl[9]);
    @(posedge clk); #1; we = 0;
    mdl[9] = 64'hCAFE_F00D_0000_0009;
    rd_both(9, 1, 3, 0, "R7 new value next cycle");

    // PC sequencing (R8, R9)
    pc_step = 1; tick();
    chk("R8 step pc", pc_out, RV + 64'd4);
    chk("R8 step npc", npc_out, RV + 64'd8);
    npc_load = 1; npc_value = 64'h2000; tick();
    chk("R9 load no step pc", pc_out, RV + 64'd4);
    chk("R9 load no step npc", npc_out, 64'h2000);
    pc_step = 1; tick();
    chk("R8 step after load pc", pc_out, 64'h2000);
    chk("R8 step after load npc", npc_out, 64'h2004);
    npc_branch = 1; npc_value = -64'sd16; pc_step = 1; tick();
    chk("R9 branch with step pc", pc_out, 64'h1FF0);
    chk("R9 branch with step npc", npc_out, 64'h1FF4);
    npc_branch = 1; npc_load = 1; npc_value = 64'h40; tick();
    chk("R9 load beats branch npc", npc_out, 64'h40);
    chk("R9 load beats branch pc", pc_out, 64'h1FF0);
    npc_branch = 1; npc_value = 64'h100; tick();
    chk("R9 branch no step npc", npc_out, 64'h20F0);
    tick();
    chk("R9 idle npc", npc_out, 64'h20F0);

    // link save beats write port (R10)
    link_save = 1; we = 1; wr_idx = 30; wr_sp = 1; wr_width = 3; wr_data = 64'hBAD0;
    tick(); we = 0;
    mdl[30] = 64'h20F0;
    rd_both(30, 1, 3, 0, "R10 link save");

    // mid-run reset (R11)
    @(negedge clk); rst_n = 0; #1;
    for (int i = 0; i < 32; i++) mdl[i] = 64'd0;
    for (int i = 0; i < 32; i++) rd_both(i, 1, 3, 0, "R11 reset mid-run");
    chk("R11 reset pc mid-run", pc_out, RV);
    chk("R11 reset npc mid-run", npc_out, RV + 64'd4);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule